// File: doc/BRIEF.md
# Masked Vector Floating-Point Classify Engine

The engine runs one vector classify operation over a flat register image. A start pulse hands it an element width, an active length, the length of the full register group, a mask-enable flag and a mask stride. From the next cycle on it takes one element index per cycle. For an active element, it reads the source element, sorts the element into one of ten floating-point categories, and writes a one-hot category code into the destination element at the same index. A mask can suppress the write for an active element. Every element beyond the active length up to the end of the group is written with zero.

Source, mask and destination storage stay outside the block. The engine drives an element index and a mask bit address, and gets the source element and the mask bit back in the same cycle. It issues at most one destination write per cycle. It raises a one-cycle completion pulse when the last element slot has been handled.

Top module: `vclass_engine`

## Requirements
- R1: After reset, `busy`, `done` and `dst_we` are 0, and they stay 0 until a start is accepted.
- R2: A start accepted at a clock edge with group length N is followed by N element slots, one per cycle, for indices 0, 1, ..., N-1 in ascending order. `src_idx` and `dst_idx` both carry the slot's index.
- R3: The code written for an active element has exactly one bit set in bits 9:0, and all higher bits are 0. The bits mean: 0 negative infinity, 1 negative normal, 2 negative subnormal, 3 negative zero, 4 positive zero, 5 positive subnormal, 6 positive normal, 7 positive infinity, 8 signalling NaN (top mantissa bit clear), 9 quiet NaN (top mantissa bit set).
- R4: `ew` selects the element format: 0 is half precision (bits 15:0, 5-bit exponent), 1 is single (bits 31:0, 8-bit exponent), and 2 or 3 is double (bits 63:0, 11-bit exponent). Source bits above the element are ignored.
- R5: When `vm` is 0, the mask bit of element i is read at bit address i*`mlen`. If that bit is 0, the slot of element i makes no write, so the destination element keeps its old value.
- R6: When `vm` is 1, every active element is written whatever the mask bits are.
- R7: Each slot whose index is at or above the active length writes the value 0.
- R8: With an active length of 0, every one of the N slots writes 0 and no category code is written.
- R9: `done` is 1 for exactly one cycle, the cycle right after the last element slot. With N = 0 this is the cycle right after the start. `busy` is 1 from the first slot through the `done` cycle.
- R10: A start that arrives while `busy` is 1 is ignored. The running operation keeps its own parameters.
- R11: An active length larger than the group length is treated as equal to the group length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an operation when idle |
| ew | input | 2 | Element format select |
| vl | input | 7 | Active element count |
| vlmax | input | 7 | Group element count N |
| vm | input | 1 | 1 = mask not used |
| mlen | input | 7 | Mask bit stride per element |
| src_idx | output | 6 | Source element index |
| src_data | input | 64 | Source element, low-aligned |
| mask_addr | output | 12 | Mask register bit address |
| mask_bit | input | 1 | Mask bit at mask_addr |
| dst_we | output | 1 | Destination write enable |
| dst_idx | output | 6 | Destination element index |
| dst_wdata | output | 64 | Destination element value |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The start is sampled at a rising edge. The slot of element k is then visible on the write port during cycle k+1 after that edge, and `done` is due in cycle N+1. The write lands in the destination image at the edge that closes its slot. The bench raises start half a cycle before the sampling edge. It then steps one falling edge at a time, checks each slot's enable, index and data at the falling edge of exactly that cycle, checks the pulse at the following falling edge, and compares the whole destination image once the operation is over.

// File: rtl/vclass_pkg.sv
package vclass_pkg;

  typedef enum logic [1:0] {
    EW_HALF   = 2'd0,
    EW_SINGLE = 2'd1,
    EW_DOUBLE = 2'd2,
    EW_ALIAS  = 2'd3
  } ew_e;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_ACT  = 2'd1,
    PH_TAIL = 2'd2,
    PH_FIN  = 2'd3
  } phase_e;

  localparam int CODE_W = 10;
  localparam int NUM_FMT = 3;

  function automatic int fmt_exp_w(input int g);
    case (g)
      0:       return 5;
      1:       return 8;
      default: return 11;
    endcase
  endfunction

  function automatic int fmt_man_w(input int g);
    case (g)
      0:       return 10;
      1:       return 23;
      default: return 52;
    endcase
  endfunction

  // Category from decoded fields; bit order follows the R3 table.
  function automatic logic [CODE_W-1:0] class_code(
    input logic sgn,
    input logic exp_ones,
    input logic exp_zero,
    input logic man_zero,
    input logic man_top
  );
    logic [CODE_W-1:0] c;
    c = '0;
    if (exp_ones && man_zero)      c[sgn ? 0 : 7] = 1'b1;
    else if (exp_ones)             c[man_top ? 9 : 8] = 1'b1;
    else if (exp_zero && man_zero) c[sgn ? 3 : 4] = 1'b1;
    else if (exp_zero)             c[sgn ? 2 : 5] = 1'b1;
    else                           c[sgn ? 1 : 6] = 1'b1;
    return c;
  endfunction

endpackage

// File: rtl/vclass_classifier.sv
module vclass_classifier
  import vclass_pkg::*;
(
  input  logic [63:0]       raw,
  input  logic [1:0]        ew,
  output logic [CODE_W-1:0] code
);

  logic [CODE_W-1:0] codes [NUM_FMT];

  for (genvar g = 0; g < NUM_FMT; g++) begin : g_fmt
    localparam int EXW = fmt_exp_w(g);
    localparam int MNW = fmt_man_w(g);
    logic           sgn;
    logic [EXW-1:0] ex;
    logic [MNW-1:0] mn;
    assign sgn = raw[EXW+MNW];
    assign ex  = raw[MNW +: EXW];
    assign mn  = raw[0 +: MNW];
    assign codes[g] = class_code(sgn, &ex, ~|ex, ~|mn, mn[MNW-1]);
  end

  always_comb begin
    case (ew_e'(ew))
      EW_HALF:   code = codes[0];
      EW_SINGLE: code = codes[1];
      default:   code = codes[2];
    endcase
  end

endmodule

// File: rtl/vclass_seq.sv
module vclass_seq
  import vclass_pkg::*;
#(
  parameter int EIDX_W = 6,
  parameter int CNT_W  = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [CNT_W-1:0]  vl,
  input  logic [CNT_W-1:0]  vlmax,
  output phase_e            phase,
  output logic [EIDX_W-1:0] idx,
  output logic              launch,
  output logic              slot_v
);

  logic [CNT_W-1:0] vl_q, vlmax_q, vl_eff, idx_ext;

  assign vl_eff  = (vl > vlmax) ? vlmax : vl;
  assign launch  = (phase == PH_IDLE) && start;
  assign slot_v  = (phase == PH_ACT) || (phase == PH_TAIL);
  assign idx_ext = CNT_W'(idx);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase   <= PH_IDLE;
      idx     <= '0;
      vl_q    <= '0;
      vlmax_q <= '0;
    end else begin
      case (phase)
        PH_IDLE: begin
          if (start) begin
            vl_q    <= vl_eff;
            vlmax_q <= vlmax;
            idx     <= '0;
            if (vlmax == '0)       phase <= PH_FIN;
            else if (vl_eff == '0) phase <= PH_TAIL;
            else                   phase <= PH_ACT;
          end
        end
        PH_ACT: begin
          idx <= idx + 1'b1;
          if (idx_ext == vl_q - 1'b1)
            phase <= (vl_q == vlmax_q) ? PH_FIN : PH_TAIL;
        end
        PH_TAIL: begin
          idx <= idx + 1'b1;
          if (idx_ext == vlmax_q - 1'b1) phase <= PH_FIN;
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/vclass_mask_sel.sv
module vclass_mask_sel #(
  parameter int EIDX_W = 6,
  parameter int MLEN_W = 7,
  parameter int MB_W   = 12
) (
  input  logic [EIDX_W-1:0] idx,
  input  logic [MLEN_W-1:0] mlen,
  input  logic              vm,
  input  logic              mask_bit,
  output logic [MB_W-1:0]   mask_addr,
  output logic              enabled
);

  function automatic logic [MB_W-1:0] bit_pos(
    input logic [EIDX_W-1:0] i,
    input logic [MLEN_W-1:0] m
  );
    return MB_W'(i) * MB_W'(m);
  endfunction

  assign mask_addr = bit_pos(idx, mlen);
  assign enabled   = vm || mask_bit;

endmodule

// File: rtl/vclass_engine.sv
module vclass_engine
  import vclass_pkg::*;
#(
  parameter int MAX_ELEMS = 64,
  parameter int MLEN_MAX  = 64,
  localparam int EIDX_W   = $clog2(MAX_ELEMS),
  localparam int CNT_W    = $clog2(MAX_ELEMS + 1),
  localparam int MLEN_W   = $clog2(MLEN_MAX + 1),
  localparam int MB_W     = $clog2(MAX_ELEMS * MLEN_MAX)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [1:0]        ew,
  input  logic [CNT_W-1:0]  vl,
  input  logic [CNT_W-1:0]  vlmax,
  input  logic              vm,
  input  logic [MLEN_W-1:0] mlen,
  output logic [EIDX_W-1:0] src_idx,
  input  logic [63:0]       src_data,
  output logic [MB_W-1:0]   mask_addr,
  input  logic              mask_bit,
  output logic              dst_we,
  output logic [EIDX_W-1:0] dst_idx,
  output logic [63:0]       dst_wdata,
  output logic              busy,
  output logic              done
);

  phase_e            phase;
  logic [EIDX_W-1:0] idx;
  logic              launch, slot_v, enabled;
  logic              elem_fire, elem_skip, tail_fire;
  logic [1:0]        ew_q;
  logic              vm_q;
  logic [MLEN_W-1:0] mlen_q;
  logic [CODE_W-1:0] code;

  vclass_seq #(.EIDX_W(EIDX_W), .CNT_W(CNT_W)) u_seq (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .vl     (vl),
    .vlmax  (vlmax),
    .phase  (phase),
    .idx    (idx),
    .launch (launch),
    .slot_v (slot_v)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ew_q   <= '0;
      vm_q   <= 1'b1;
      mlen_q <= '0;
    end else if (launch) begin
      ew_q   <= ew;
      vm_q   <= vm;
      mlen_q <= mlen;
    end
  end

  vclass_mask_sel #(.EIDX_W(EIDX_W), .MLEN_W(MLEN_W), .MB_W(MB_W)) u_mask (
    .idx       (idx),
    .mlen      (mlen_q),
    .vm        (vm_q),
    .mask_bit  (mask_bit),
    .mask_addr (mask_addr),
    .enabled   (enabled)
  );

  vclass_classifier u_cls (
    .raw  (src_data),
    .ew   (ew_q),
    .code (code)
  );

  assign elem_fire = (phase == PH_ACT) && enabled;
  assign elem_skip = (phase == PH_ACT) && !enabled;
  assign tail_fire = (phase == PH_TAIL);

  assign src_idx   = idx;
  assign dst_idx   = idx;
  assign dst_we    = elem_fire || tail_fire;
  assign dst_wdata = elem_fire ? {{(64-CODE_W){1'b0}}, code} : 64'd0;
  assign busy      = (phase != PH_IDLE);
  assign done      = (phase == PH_FIN);

endmodule

// File: rtl/vclass_engine_chk.sv
module vclass_engine_chk #(
  parameter int EIDX_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              busy,
  input logic              done,
  input logic              dst_we,
  input logic [EIDX_W-1:0] dst_idx,
  input logic [63:0]       dst_wdata,
  input logic              launch,
  input logic              slot_v,
  input logic              elem_fire,
  input logic              elem_skip,
  input logic              tail_fire
);

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!dst_we && !done));

  p_ascending_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_v && $past(slot_v)) |-> (dst_idx == EIDX_W'($past(dst_idx) + 1'b1)));

  p_onehot_code_r3: assert property (@(posedge clk) disable iff (!rst_n)
    elem_fire |-> (dst_we && $countones(dst_wdata[9:0]) == 1 && dst_wdata[63:10] == '0));

  p_skip_no_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
    elem_skip |-> !dst_we);

  p_tail_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    tail_fire |-> (dst_we && dst_wdata == 64'd0));

  p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_after_slot_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(slot_v) |-> done);

  p_busy_no_launch_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |-> !launch);

endmodule

bind vclass_engine vclass_engine_chk #(.EIDX_W(EIDX_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .busy      (busy),
  .done      (done),
  .dst_we    (dst_we),
  .dst_idx   (dst_idx),
  .dst_wdata (dst_wdata),
  .launch    (launch),
  .slot_v    (slot_v),
  .elem_fire (elem_fire),
  .elem_skip (elem_skip),
  .tail_fire (tail_fire)
);

// File: tb/sim_vclass_engine.sv
module sim_vclass_engine;

  localparam int CLK_PERIOD = 10;
  localparam int NE = 64;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [1:0]  ew = 2'd0;
  logic [6:0]  vl = '0, vlmax = '0, mlen = 7'd1;
  logic        vm = 1'b1;
  logic [5:0]  src_idx, dst_idx;
  logic [63:0] src_data, dst_wdata;
  logic [11:0] mask_addr;
  logic        mask_bit, dst_we, busy, done;

  logic [63:0]   src_mem [NE];
  logic [63:0]   dst_mem [NE];
  logic [63:0]   exp_mem [NE];
  logic [4095:0] mask_reg;

  int n_cmp = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign src_data = src_mem[src_idx];
  assign mask_bit = mask_reg[mask_addr];

  always @(posedge clk) if (dst_we) dst_mem[dst_idx] <= dst_wdata;

  vclass_engine u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .ew(ew), .vl(vl), .vlmax(vlmax),
    .vm(vm), .mlen(mlen), .src_idx(src_idx), .src_data(src_data),
    .mask_addr(mask_addr), .mask_bit(mask_bit), .dst_we(dst_we),
    .dst_idx(dst_idx), .dst_wdata(dst_wdata), .busy(busy), .done(done)
  );

  task automatic check(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] expv);
    n_cmp++;
    if (act !== expv) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, expv);
    end
  endtask

  // Build a source value of category cls for the given format.
  function automatic logic [63:0] make_val(input int fmt, input int cls, input int k);
    int ewid, mwid;
    logic [63:0] e1, mtop, v, s;
    ewid = (fmt == 0) ? 5 : (fmt == 1) ? 8 : 11;
    mwid = (fmt == 0) ? 10 : (fmt == 1) ? 23 : 52;
    e1   = (64'd1 << ewid) - 1;
    mtop = 64'd1 << (mwid - 1);
    s    = 64'd1 << (ewid + mwid);
    case (cls)
      0: v = s | (e1 << mwid);
      1: v = s | (64'd1 << mwid) | 64'(k);
      2: v = s | 64'(k + 1);
      3: v = s;
      4: v = 64'd0;
      5: v = 64'(k + 3);
      6: v = (64'd2 << mwid) | 64'(k);
      7: v = e1 << mwid;
      8: v = (e1 << mwid) | 64'd1;
      default: v = (e1 << mwid) | mtop | 64'(k);
    endcase
    if (fmt < 2) v = v | (64'hA5C3_5A3C_96E1_0F78 << (ewid + mwid + 1));
    return v;
  endfunction

  // Prepare images, run one operation and check each slot at its cycle.
  task automatic run_case(input string req, input int fmt, input logic [1:0] ew_code,
                          input int vl_i, input int vlmax_i, input logic vm_i,
                          input int mlen_i, input int seed, input bit poke);
    int vle;
    bit en;
    logic [63:0] ev;
    vle = (vl_i > vlmax_i) ? vlmax_i : vl_i;
    mask_reg = '0;
    for (int i = 0; i < NE; i++) begin
      src_mem[i] = make_val(fmt, (i * 3 + seed) % 10, i);
      dst_mem[i] = 64'hF00D_0000_0000_0000 | 64'(i);
      if ((i + seed) % 3 != 1) mask_reg[i * mlen_i] = 1'b1;
    end
    for (int i = 0; i < NE; i++) exp_mem[i] = dst_mem[i];
    @(negedge clk);
    ew = ew_code; vl = 7'(vl_i); vlmax = 7'(vlmax_i); vm = vm_i; mlen = 7'(mlen_i);
    start = 1'b1;
    @(negedge clk);
    if (!poke) start = 1'b0;
    else begin vl = 7'd0; vlmax = 7'd1; vm = 1'b0; ew = 2'd1; end
    for (int s = 0; s < vlmax_i; s++) begin
      en = vm_i || mask_reg[s * mlen_i];
      if (s < vle) ev = 64'd1 << ((s * 3 + seed) % 10);
      else         ev = 64'd0;
      if (s < vle && !en) begin
        check(req, $sformatf("skip we slot %0d", s), 64'(dst_we), 64'd0);
      end else begin
        check(req, $sformatf("we slot %0d", s), 64'(dst_we), 64'd1);
        check("R2", $sformatf("index slot %0d", s), 64'(dst_idx), 64'(s));
        check(req, $sformatf("data slot %0d", s), dst_wdata, ev);
        exp_mem[s] = ev;
      end
      check("R9", $sformatf("busy slot %0d", s), 64'(busy), 64'd1);
      check("R9", $sformatf("done early slot %0d", s), 64'(done), 64'd0);
      @(negedge clk);
    end
    start = 1'b0;
    check("R9", "done pulse", 64'(done), 64'd1);
    @(negedge clk);
    check("R9", "done cleared", 64'(done), 64'd0);
    check("R9", "busy cleared", 64'(busy), 64'd0);
    for (int i = 0; i < NE; i++)
      check(req, $sformatf("image elem %0d", i), dst_mem[i], exp_mem[i]);
  endtask

  task automatic t_reset;
    check("R1", "busy", 64'(busy), 64'd0);
    check("R1", "done", 64'(done), 64'd0);
    check("R1", "we", 64'(dst_we), 64'd0);
  endtask

  task automatic t_half_unmasked;   run_case("R3", 0, 2'd0, 20, 20, 1'b1, 1, 0, 0); endtask
  task automatic t_single_masked;   run_case("R5", 1, 2'd1, 12, 16, 1'b0, 4, 1, 0); endtask
  task automatic t_double_vm_set;   run_case("R6", 2, 2'd2, 10, 10, 1'b1, 8, 2, 0); endtask
  task automatic t_double_tail;     run_case("R7", 2, 2'd2, 5, 32, 1'b0, 2, 4, 0); endtask
  task automatic t_vl_zero;         run_case("R8", 1, 2'd1, 0, 9, 1'b1, 1, 5, 0); endtask
  task automatic t_clamp;           run_case("R11", 0, 2'd0, 40, 8, 1'b1, 1, 6, 0); endtask
  task automatic t_busy_start;      run_case("R10", 0, 2'd0, 6, 11, 1'b0, 3, 7, 1); endtask
  task automatic t_alias_width;     run_case("R4", 2, 2'd3, 10, 12, 1'b1, 1, 3, 0); endtask
  task automatic t_full_group;      run_case("R2", 1, 2'd1, 64, 64, 1'b0, 64, 8, 0); endtask
  task automatic t_empty_group;     run_case("R9", 0, 2'd0, 0, 0, 1'b1, 1, 0, 0); endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_half_unmasked();
    t_single_masked();
    t_double_vm_set();
    t_double_tail();
    t_vl_zero();
    t_clamp();
    t_busy_start();
    t_alias_width();
    t_full_group();
    t_empty_group();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule